// File: doc/BRIEF.md
# Significand Rounding Stage with Selectable Precision

This block rounds a floating-point significand. It takes an unrounded 64-bit significand, the three extra bits below it (guard, round and sticky) and the sign of the value. It rounds the significand to the precision and the rounding direction that a 16-bit control word selects. The result appears one clock cycle after the input. This delay is the same at every precision.

A reduced precision moves the rounding point up the significand. Every bit below the kept field feeds the rounding decision and is cleared in the result. When rounding overflows the kept field, a carry-out tells the exponent logic downstream to add one, and the significand becomes 1.000…0. An inexact flag reports that nonzero bits were discarded.

The low six bits of the control word are exception mask bits. They do not affect rounding. They travel beside the result so that later stages can use them.

Top module: `sig_round`

## Requirements
- R1: Every accepted input (`in_valid` high at a rising edge) gives a result with `out_valid` high exactly one cycle later, for every precision and rounding setting. `out_valid` is low in every other cycle.
- R2: Control bits [9:8] select the kept width: 00 keeps the top 24 significand bits, 10 keeps the top 53 and 11 keeps all 64. Every result bit below the kept field is zero. The discarded bits of the significand, and the guard, round and sticky inputs, all feed the rounding decision.
- R3: Control bits [11:10] = 00 rounds to nearest. Above half increments, below half truncates, and an exact half rounds to the value whose least significant kept bit is 0.
- R4: Control bits [11:10] = 10 rounds toward +infinity. A positive value with any discarded bit set increments. A negative value truncates.
- R5: Control bits [11:10] = 01 rounds toward -infinity. A negative value with any discarded bit set increments. A positive value truncates.
- R6: Control bits [11:10] = 11 truncates toward zero, whatever the sign. It never increments and never raises the carry-out.
- R7: `out_inexact` is 1 exactly when at least one discarded bit was 1. When it is 0, the result equals the input significand and there is no carry-out.
- R8: When an increment overflows the kept field, `out_carry` is 1 and `out_sig` is 1 followed by zeros (only bit 63 set).
- R9: Control bits [5:0] have no effect on the result and appear unchanged on `out_exc_mask` in the result cycle.
- R10: Precision code 01 is reserved and behaves exactly like code 11 (64 bits).
- R11: While reset is asserted and right after it, `out_valid`, `out_sig`, `out_carry` and `out_inexact` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input is present this cycle |
| in_sign | input | 1 | Sign of the value, 1 for negative |
| in_sig | input | 64 | Unrounded significand, bit 63 most significant |
| in_guard | input | 1 | First bit below the significand |
| in_round | input | 1 | Second bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| in_ctrl | input | 16 | Control word: [11:10] rounding, [9:8] precision, [5:0] masks |
| out_valid | output | 1 | Result is present this cycle |
| out_sign | output | 1 | Sign carried along with the result |
| out_sig | output | 64 | Rounded significand |
| out_carry | output | 1 | Rounding overflowed; exponent must increase by one |
| out_inexact | output | 1 | Some discarded bit was nonzero |
| out_exc_mask | output | 6 | Mask bits passed through from the control word |

## Verification
Nearest rounding is tried with values exactly at half, just above half and just below half, each with an odd and an even least significant kept bit, so that ties-to-even can be told apart from round-half-up. The directed modes are each run with both signs on the same significand, which shows whether the sign steers the increment. Each precision gets a case whose only set discarded bit lies inside the dropped field, and another where it lies in the guard, round or sticky inputs. A reserved-code case with a pattern that rounds differently at 24 bits proves that 01 falls back to 64 bits. All-ones significands exercise the carry-out at both the narrowest and the full width.

// File: rtl/sig_round_pkg.sv
package sig_round_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_CHOP    = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        PC_NARROW = 2'b00,
        PC_RSVD   = 2'b01,
        PC_MID    = 2'b10,
        PC_FULL   = 2'b11
    } pcode_e;

    localparam int CTRL_PC_LSB = 8;
    localparam int CTRL_RM_LSB = 10;
    localparam int MASK_W      = 6;

endpackage

// File: rtl/rnd_prec_sel.sv
module rnd_prec_sel
    import sig_round_pkg::*;
#(
    parameter int SIG_W = 64,
    parameter int W_LO  = 24,
    parameter int W_MID = 53
) (
    input  logic [SIG_W-1:0] sig,
    input  logic             g_in,
    input  logic             r_in,
    input  logic             s_in,
    input  pcode_e           pcode,
    output logic [SIG_W-1:0] keep_mask,
    output logic [SIG_W-1:0] unit,
    output logic             rbit,
    output logic             sticky
);
    localparam int NARROW_IDX = 0;
    localparam int MID_IDX    = 1;
    localparam int NUM_RED    = 2;

    logic [SIG_W-1:0] red_keep  [NUM_RED];
    logic [SIG_W-1:0] red_unit  [NUM_RED];
    logic             red_rbit  [NUM_RED];
    logic             red_stk   [NUM_RED];

    // One rounding-point variant for each reduced width
    for (genvar k = 0; k < NUM_RED; k++) begin : g_red
        localparam int WK = (k == NARROW_IDX) ? W_LO : W_MID;
        localparam logic [SIG_W-1:0] ONES   = {SIG_W{1'b1}};
        localparam logic [SIG_W-1:0] KEEP_K = ~(ONES >> WK);
        localparam logic [SIG_W-1:0] UNIT_K = SIG_W'(1) << (SIG_W - WK);
        localparam logic [SIG_W-1:0] RB_K   = UNIT_K >> 1;
        localparam logic [SIG_W-1:0] BELOW_K = RB_K - SIG_W'(1);

        assign red_keep[k] = KEEP_K;
        assign red_unit[k] = UNIT_K;
        assign red_rbit[k] = |(sig & RB_K);
        assign red_stk[k]  = (|(sig & BELOW_K)) | g_in | r_in | s_in;
    end

    always_comb begin
        case (pcode)
            PC_NARROW: begin
                keep_mask = red_keep[NARROW_IDX];
                unit      = red_unit[NARROW_IDX];
                rbit      = red_rbit[NARROW_IDX];
                sticky    = red_stk[NARROW_IDX];
            end
            PC_MID: begin
                keep_mask = red_keep[MID_IDX];
                unit      = red_unit[MID_IDX];
                rbit      = red_rbit[MID_IDX];
                sticky    = red_stk[MID_IDX];
            end
            default: begin
                // full width; the reserved code lands here as well
                keep_mask = {SIG_W{1'b1}};
                unit      = SIG_W'(1);
                rbit      = g_in;
                sticky    = r_in | s_in;
            end
        endcase
    end

endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
    import sig_round_pkg::*;
(
    input  rmode_e mode,
    input  logic   sign,
    input  logic   lsb,
    input  logic   rbit,
    input  logic   sticky,
    output logic   inc,
    output logic   inexact
);
    logic lost;

    always_comb begin
        lost = rbit | sticky;
        case (mode)
            RM_NEAREST: inc = rbit & (sticky | lsb);
            RM_UP:      inc = lost & ~sign;
            RM_DOWN:    inc = lost & sign;
            default:    inc = 1'b0;
        endcase
        inexact = lost;
    end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int SIG_W = 64
) (
    input  logic [SIG_W-1:0] kept,
    input  logic [SIG_W-1:0] unit,
    input  logic             inc,
    output logic [SIG_W-1:0] sig_out,
    output logic             carry
);
    localparam logic [SIG_W-1:0] TOP_ONE = {1'b1, {(SIG_W-1){1'b0}}};

    logic [SIG_W:0] sum;

    always_comb begin
        sum     = {1'b0, kept} + {1'b0, (inc ? unit : {SIG_W{1'b0}})};
        carry   = sum[SIG_W];
        sig_out = carry ? TOP_ONE : sum[SIG_W-1:0];
    end

endmodule

// File: rtl/sig_round.sv
module sig_round
    import sig_round_pkg::*;
#(
    parameter int SIG_W  = 64,
    parameter int CTRL_W = 16,
    parameter int W_LO   = 24,
    parameter int W_MID  = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [SIG_W-1:0]  in_sig,
    input  logic              in_guard,
    input  logic              in_round,
    input  logic              in_sticky,
    input  logic [CTRL_W-1:0] in_ctrl,
    output logic              out_valid,
    output logic              out_sign,
    output logic [SIG_W-1:0]  out_sig,
    output logic              out_carry,
    output logic              out_inexact,
    output logic [MASK_W-1:0] out_exc_mask
);
    localparam logic [SIG_W-1:0] TOP_ONE = {1'b1, {(SIG_W-1){1'b0}}};
    localparam int LO_DROP = SIG_W - W_LO;
    localparam int MID_DROP = SIG_W - W_MID;

    typedef struct packed {
        logic              valid;
        logic              sign;
        logic [SIG_W-1:0]  sig;
        logic              carry;
        logic              inexact;
        logic [MASK_W-1:0] mask;
    } stage_t;

    stage_t st_d, st_q;

    pcode_e           pcode;
    rmode_e           rmode;
    logic [SIG_W-1:0] keep_mask;
    logic [SIG_W-1:0] unit;
    logic             rbit;
    logic             sticky;
    logic             lsb;
    logic             inc;
    logic             inexact;
    logic [SIG_W-1:0] rounded;
    logic             carry;

    assign pcode = pcode_e'(in_ctrl[CTRL_PC_LSB +: 2]);
    assign rmode = rmode_e'(in_ctrl[CTRL_RM_LSB +: 2]);
    assign lsb   = |(in_sig & unit);

    rnd_prec_sel #(
        .SIG_W (SIG_W),
        .W_LO  (W_LO),
        .W_MID (W_MID)
    ) u_prec (
        .sig       (in_sig),
        .g_in      (in_guard),
        .r_in      (in_round),
        .s_in      (in_sticky),
        .pcode     (pcode),
        .keep_mask (keep_mask),
        .unit      (unit),
        .rbit      (rbit),
        .sticky    (sticky)
    );

    rnd_decide u_dec (
        .mode    (rmode),
        .sign    (in_sign),
        .lsb     (lsb),
        .rbit    (rbit),
        .sticky  (sticky),
        .inc     (inc),
        .inexact (inexact)
    );

    rnd_incr #(
        .SIG_W (SIG_W)
    ) u_inc (
        .kept    (in_sig & keep_mask),
        .unit    (unit),
        .inc     (inc),
        .sig_out (rounded),
        .carry   (carry)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.sign    = in_sign;
        st_d.sig     = rounded;
        st_d.carry   = carry;
        st_d.inexact = inexact;
        st_d.mask    = in_ctrl[MASK_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.valid;
    assign out_sign     = st_q.sign;
    assign out_sig      = st_q.sig;
    assign out_carry    = st_q.carry;
    assign out_inexact  = st_q.inexact;
    assign out_exc_mask = st_q.mask;

    // R1: a result follows each accepted input after exactly one edge
    a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    a_r1_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(rst_n)) |-> out_valid);

    // R2: bits below a reduced kept field are cleared
    a_r2_narrow_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_ctrl[CTRL_PC_LSB +: 2]) == PC_NARROW)
            |-> out_sig[LO_DROP-1:0] == '0);
    a_r2_mid_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_ctrl[CTRL_PC_LSB +: 2]) == PC_MID)
            |-> out_sig[MID_DROP-1:0] == '0);

    // R6: truncation never overflows
    a_r6_chop_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_ctrl[CTRL_RM_LSB +: 2]) == RM_CHOP) |-> !out_carry);

    // R7: an exact input leaves the significand untouched
    a_r7_exact_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_inexact) |-> (out_sig == $past(in_sig) && !out_carry));

    // R8: overflow yields 1.000...0
    a_r8_carry_value: assert property (@(posedge clk) disable iff (!rst_n)
        out_carry |-> (out_sig == TOP_ONE && out_inexact));

    // R9: mask bits travel with the result
    a_r9_mask_pass: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_exc_mask == $past(in_ctrl[MASK_W-1:0]));

endmodule

// File: tb/sig_round_test.sv
module sig_round_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_sign;
    logic [63:0] in_sig;
    logic        in_guard;
    logic        in_round;
    logic        in_sticky;
    logic [15:0] in_ctrl;
    logic        out_valid;
    logic        out_sign;
    logic [63:0] out_sig;
    logic        out_carry;
    logic        out_inexact;
    logic [5:0]  out_exc_mask;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [1:0] P24 = 2'b00, PRS = 2'b01, P53 = 2'b10, P64 = 2'b11;
    localparam logic [1:0] NE = 2'b00, DN = 2'b01, UP = 2'b10, CH = 2'b11;

    always #5 clk = ~clk;

    sig_round uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sign      (in_sign),
        .in_sig       (in_sig),
        .in_guard     (in_guard),
        .in_round     (in_round),
        .in_sticky    (in_sticky),
        .in_ctrl      (in_ctrl),
        .out_valid    (out_valid),
        .out_sign     (out_sign),
        .out_sig      (out_sig),
        .out_carry    (out_carry),
        .out_inexact  (out_inexact),
        .out_exc_mask (out_exc_mask)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_case(input string tag, input logic sgn, input logic [63:0] sig,
                            input logic g, input logic r, input logic s,
                            input logic [1:0] pc, input logic [1:0] rm, input logic [5:0] msk,
                            input logic [63:0] e_sig, input logic e_c, input logic e_i);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sign   = sgn;
        in_sig    = sig;
        in_guard  = g;
        in_round  = r;
        in_sticky = s;
        in_ctrl   = {4'b0000, rm, pc, 2'b00, msk};
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R1 valid"}, 64'(out_valid), 64'd1);
        chk({tag, " sig"}, out_sig, e_sig);
        chk({tag, " R8 carry"}, 64'(out_carry), 64'(e_c));
        chk({tag, " R7 inexact"}, 64'(out_inexact), 64'(e_i));
        chk({tag, " R9 mask"}, 64'(out_exc_mask), 64'(msk));
        chk({tag, " sign"}, 64'(out_sign), 64'(sgn));
        @(negedge clk);
        chk({tag, " R1 valid drops"}, 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 valid", 64'(out_valid), 64'd0);
        chk("R11 sig", out_sig, 64'd0);
        chk("R11 carry", 64'(out_carry), 64'd0);
        chk("R11 inexact", 64'(out_inexact), 64'd0);
    endtask

    task automatic t_nearest();
        run_case("R3 tie even", 0, 64'h8000_0000_0000_0002, 1, 0, 0, P64, NE, 6'h00,
                 64'h8000_0000_0000_0002, 0, 1);
        run_case("R3 tie odd", 0, 64'h8000_0000_0000_0003, 1, 0, 0, P64, NE, 6'h00,
                 64'h8000_0000_0000_0004, 0, 1);
        run_case("R3 above half", 0, 64'h8000_0000_0000_0002, 1, 1, 0, P64, NE, 6'h00,
                 64'h8000_0000_0000_0003, 0, 1);
        run_case("R3 below half", 0, 64'h8000_0000_0000_0003, 0, 1, 1, P64, NE, 6'h00,
                 64'h8000_0000_0000_0003, 0, 1);
    endtask

    task automatic t_directed();
        run_case("R4 up pos", 0, 64'h8000_0000_0000_0400, 0, 0, 0, P53, UP, 6'h00,
                 64'h8000_0000_0000_0800, 0, 1);
        run_case("R4 up neg", 1, 64'h8000_0000_0000_0400, 0, 0, 0, P53, UP, 6'h00,
                 64'h8000_0000_0000_0000, 0, 1);
        run_case("R5 down neg", 1, 64'h8000_0000_0000_0400, 0, 0, 0, P53, DN, 6'h00,
                 64'h8000_0000_0000_0800, 0, 1);
        run_case("R5 down pos", 0, 64'h8000_0000_0000_0400, 0, 0, 0, P53, DN, 6'h00,
                 64'h8000_0000_0000_0000, 0, 1);
    endtask

    task automatic t_chop();
        run_case("R6 chop 24", 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, P24, CH, 6'h00,
                 64'hFFFF_FF00_0000_0000, 0, 1);
        run_case("R6 chop neg", 1, 64'h8000_0000_0000_0005, 1, 1, 0, P64, CH, 6'h00,
                 64'h8000_0000_0000_0005, 0, 1);
    endtask

    task automatic t_precision();
        run_case("R2 24 tie even", 0, 64'h8000_0080_0000_0000, 0, 0, 0, P24, NE, 6'h00,
                 64'h8000_0000_0000_0000, 0, 1);
        run_case("R2 24 tie odd", 0, 64'h8000_0180_0000_0000, 0, 0, 0, P24, NE, 6'h00,
                 64'h8000_0200_0000_0000, 0, 1);
        run_case("R2 24 input sticky", 0, 64'h8000_0000_0000_0000, 0, 0, 1, P24, UP, 6'h00,
                 64'h8000_0100_0000_0000, 0, 1);
        run_case("R2 53 sticky only NE", 0, 64'h8000_0000_0000_0001, 0, 0, 0, P53, NE, 6'h00,
                 64'h8000_0000_0000_0000, 0, 1);
        run_case("R2 53 sticky only UP", 0, 64'h8000_0000_0000_0001, 0, 0, 0, P53, UP, 6'h00,
                 64'h8000_0000_0000_0800, 0, 1);
        run_case("R7 53 exact", 0, 64'hFFFF_FFFF_FFFF_F800, 0, 0, 0, P53, UP, 6'h00,
                 64'hFFFF_FFFF_FFFF_F800, 0, 0);
        run_case("R7 64 exact", 1, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, P64, DN, 6'h00,
                 64'h1234_5678_9ABC_DEF0, 0, 0);
        run_case("R8 64 overflow", 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, P64, NE, 6'h00,
                 64'h8000_0000_0000_0000, 1, 1);
        run_case("R8 24 overflow", 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, P24, NE, 6'h00,
                 64'h8000_0000_0000_0000, 1, 1);
    endtask

    task automatic t_reserved();
        run_case("R10 rsvd NE", 0, 64'h8000_0000_0000_0003, 1, 0, 0, PRS, NE, 6'h00,
                 64'h8000_0000_0000_0004, 0, 1);
        run_case("R10 rsvd chop", 0, 64'h8000_0000_0000_0003, 1, 0, 0, PRS, CH, 6'h00,
                 64'h8000_0000_0000_0003, 0, 1);
    endtask

    task automatic t_masks();
        run_case("R9 masks set", 0, 64'h8000_0000_0000_0003, 1, 0, 0, P64, NE, 6'h3F,
                 64'h8000_0000_0000_0004, 0, 1);
        run_case("R9 masks mixed", 1, 64'h8000_0000_0000_0400, 0, 0, 0, P53, DN, 6'h15,
                 64'h8000_0000_0000_0800, 0, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_sign   = 1'b0;
        in_sig    = '0;
        in_guard  = 1'b0;
        in_round  = 1'b0;
        in_sticky = 1'b0;
        in_ctrl   = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_nearest();
        t_directed();
        t_chop();
        t_precision();
        t_reserved();
        t_masks();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule